// File: doc/BRIEF.md
# Ring Configuration Tuning Controller

This controller tunes a reconfigurable even-stage ring oscillator used as an entropy source. Each stage of the ring picks one of several identical inverters through a small select field. The controller draws every candidate configuration word from a maximal-length LFSR and drives it onto the ring's select bus. It then collects a batch of collapse counts from the ring and keeps their running sum and their peak. A candidate passes only if two conditions hold: the batch mean lies inside a programmable window, and the peak does not exceed a programmable limit. A candidate that fails is thrown away and a fresh one is drawn. A programmable limit on the number of trials ends the search with a fail flag.

Once a candidate passes, the controller enters a monitoring state. It raises the tuned flag and the bit-accept enable, and it keeps judging every later batch against the same window. A batch whose mean leaves the window is taken as drift or as an attack. The controller then withholds output bits at once and starts a new search. A peak above the limit in any batch sets a sticky alert flag.

Collapse counts arrive on a valid/ready stream. A sample is consumed only in a cycle where `smp_valid` and `smp_ready` are both high. The source must hold the sample while `smp_ready` is low, and that can last for a whole configuration-generation phase. `smp_ready` is low in every state that does not collect samples. To avoid a divider, the mean is never computed: the sum of 2^k samples is compared against the window bounds shifted left by k.

Top module: `ring_tune_ctrl`

## Requirements
- R1: After reset the controller is idle: `smp_ready`, `tuned`, `bits_en`, `alert` and `fail` are all low and `cfg_out` is zero.
- R2: A `start` pulse is honoured only in the idle or fail state. It loads `seed` into the LFSR, with an all-zero seed replaced by 1. It clears `alert`, zeroes the trial count and latches `batch_log2`, clamped to MAX_LOG2, as k. Then a search begins.
- R3: Each trial advances the 32-bit Fibonacci LFSR CFG_W times, with no sample accepted during that phase. Each step computes fb = s[31]^s[21]^s[1]^s[0], shifts it in at bit 0 of the LFSR, and also shifts it in at bit 0 of `cfg_out`, so bit 0 holds the newest bit. The LFSR state carries over from one trial to the next.
- R4: A sample is consumed only when `smp_valid` and `smp_ready` are both high. A batch holds exactly 2^k samples, and the decision falls in the cycle after the last sample is consumed.
- R5: A batch passes when win_lo·2^k ≤ sum ≤ win_hi·2^k and peak ≤ `max_lim`. Both window bounds are inclusive.
- R6: During a search, a batch that fails R5 (mean too low, too high, or peak too large) rejects the candidate, and a new configuration is generated.
- R7: Any batch whose peak exceeds `max_lim` sets `alert`, which stays high until the next accepted `start`.
- R8: `bits_en` is high only while monitoring batches after a pass. It is low in every other state, including the decision cycle that follows each monitored batch. `tuned` is high from the pass until a monitored batch fails.
- R9: A monitored batch that fails R5 drops `tuned` and `bits_en`, resets the trial count and starts a new search.
- R10: When the number of rejected trials in a search reaches `trial_lim`, the controller enters the fail state. There `fail` is high and `smp_ready` is low until `start`.
- R11: `cfg_out` holds still for as long as samples are being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search from idle or fail |
| seed | input | 32 | LFSR seed loaded on start |
| batch_log2 | input | LOG_W | log2 of the samples per batch |
| win_lo | input | CNT_W | Lower bound of the mean window |
| win_hi | input | CNT_W | Upper bound of the mean window |
| max_lim | input | CNT_W | Largest allowed single count |
| trial_lim | input | TRIAL_W | Rejected trials allowed before failing |
| smp_valid | input | 1 | Collapse-count sample present |
| smp_ready | output | 1 | Controller accepts a sample |
| smp_count | input | CNT_W | Collapse count value |
| cfg_out | output | STAGES·SEL_W | Per-stage inverter selects for the ring |
| tuned | output | 1 | A configuration is locked |
| bits_en | output | 1 | Harvested bits may be used |
| alert | output | 1 | Sticky peak-over-limit flag |
| fail | output | 1 | Search exhausted its trial limit |

## Verification
The bench sweeps the batch mean across and past both window edges, using batches whose samples differ but whose sum is exact. A design with an exclusive bound, or one that compares a truncated mean, would flip the verdict at 70 or 85. One batch has a mean inside the window but a single sample over the peak limit. A design that ignores the peak would accept it and leave `alert` low. Monitored batches at the upper bound and one step above it show whether bits stay enabled or are withheld, and whether `bits_en` wrongly stays high in the decision cycle. Every new configuration word is compared with an independent LFSR model, a seed of zero included. A sample held valid through configuration generation exposes a controller that consumes it too early. The trial-limit case shows whether the fail state arrives exactly on the limiting rejection.

// File: rtl/ring_tune_pkg.sv
package ring_tune_pkg;
  localparam int LFSR_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GEN,
    ST_GATHER,
    ST_EVAL,
    ST_RUN,
    ST_CHECK,
    ST_FAIL
  } tune_state_t;
endpackage

// File: rtl/tune_lfsr.sv
module tune_lfsr #(
  parameter int OUT_W = 96
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [ring_tune_pkg::LFSR_W-1:0]     seed,
  input  logic                                 step,
  output logic [OUT_W-1:0]                     word
);
  import ring_tune_pkg::*;

  logic [LFSR_W-1:0] st;
  logic              fb;

  assign fb = st[31] ^ st[21] ^ st[1] ^ st[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= LFSR_W'(1);
      word <= '0;
    end else if (load) begin
      st <= (seed == '0) ? LFSR_W'(1) : seed;
    end else if (step) begin
      st   <= {st[LFSR_W-2:0], fb};
      word <= {word[OUT_W-2:0], fb};
    end
  end

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);
endmodule

// File: rtl/tune_stats.sv
module tune_stats #(
  parameter int CNT_W    = 9,
  parameter int MAX_LOG2 = 13,
  parameter int LOG_W    = 4,
  parameter int SUM_W    = CNT_W + MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [CNT_W-1:0] count,
  input  logic [LOG_W-1:0] k,
  output logic [SUM_W-1:0] sum,
  output logic [CNT_W-1:0] peak,
  output logic             last
);
  localparam int NW = MAX_LOG2 + 1;

  logic [NW-1:0] n;
  logic [NW-1:0] target;

  assign target = (NW'(1) << k) - NW'(1);
  assign last   = take && (n == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n    <= '0;
      sum  <= '0;
      peak <= '0;
    end else if (clr) begin
      n    <= '0;
      sum  <= '0;
      peak <= '0;
    end else if (take) begin
      n   <= n + NW'(1);
      sum <= sum + SUM_W'(count);
      if (count > peak) peak <= count;
    end
  end

  // R4
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> n <= target);
  // R7
  peak_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> peak >= $past(count));
endmodule

// File: rtl/ring_tune_ctrl.sv
module ring_tune_ctrl #(
  parameter int STAGES   = 32,
  parameter int SEL_W    = 3,
  parameter int CNT_W    = 9,
  parameter int MAX_LOG2 = 13,
  parameter int TRIAL_W  = 10,
  localparam int CFG_W   = STAGES * SEL_W,
  localparam int LOG_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        seed,
  input  logic [LOG_W-1:0]   batch_log2,
  input  logic [CNT_W-1:0]   win_lo,
  input  logic [CNT_W-1:0]   win_hi,
  input  logic [CNT_W-1:0]   max_lim,
  input  logic [TRIAL_W-1:0] trial_lim,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [CNT_W-1:0]   smp_count,
  output logic [CFG_W-1:0]   cfg_out,
  output logic               tuned,
  output logic               bits_en,
  output logic               alert,
  output logic               fail
);
  import ring_tune_pkg::*;

  localparam int SUM_W = CNT_W + MAX_LOG2;
  localparam int GEN_W = $clog2(CFG_W + 1);

  tune_state_t        state;
  logic [GEN_W-1:0]   gen_cnt;
  logic [TRIAL_W-1:0] trials;
  logic [LOG_W-1:0]   k_r;
  logic               go, gen_last, take, last, clr;
  logic [SUM_W-1:0]   sum, lo_s, hi_s;
  logic [CNT_W-1:0]   peak;
  logic               peak_bad, pass;

  assign go        = start && (state == ST_IDLE || state == ST_FAIL);
  assign gen_last  = (state == ST_GEN) && (gen_cnt == GEN_W'(CFG_W - 1));
  assign smp_ready = (state == ST_GATHER) || (state == ST_RUN);
  assign take      = smp_valid && smp_ready;
  assign clr       = (state == ST_GEN) || (state == ST_EVAL) || (state == ST_CHECK);
  assign tuned     = (state == ST_RUN) || (state == ST_CHECK);
  assign bits_en   = (state == ST_RUN);
  assign fail      = (state == ST_FAIL);

  assign lo_s     = SUM_W'(win_lo) << k_r;
  assign hi_s     = SUM_W'(win_hi) << k_r;
  assign peak_bad = peak > max_lim;
  assign pass     = (sum >= lo_s) && (sum <= hi_s) && !peak_bad;

  tune_lfsr #(.OUT_W(CFG_W)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (go),
    .seed (seed),
    .step (state == ST_GEN),
    .word (cfg_out)
  );

  tune_stats #(.CNT_W(CNT_W), .MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W), .SUM_W(SUM_W)) u_stats (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .take (take),
    .count(smp_count),
    .k    (k_r),
    .sum  (sum),
    .peak (peak),
    .last (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      gen_cnt <= '0;
      trials  <= '0;
      k_r     <= '0;
      alert   <= 1'b0;
    end else begin
      if (state == ST_GEN) gen_cnt <= gen_cnt + GEN_W'(1);
      unique case (state)
        ST_IDLE, ST_FAIL: if (go) begin
          state   <= ST_GEN;
          gen_cnt <= '0;
          trials  <= '0;
          alert   <= 1'b0;
          k_r     <= (batch_log2 > LOG_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : batch_log2;
        end
        ST_GEN:    if (gen_last) state <= ST_GATHER;
        ST_GATHER: if (last) state <= ST_EVAL;
        ST_EVAL: begin
          if (peak_bad) alert <= 1'b1;
          if (pass) state <= ST_RUN;
          else if (trials + TRIAL_W'(1) >= trial_lim) state <= ST_FAIL;
          else begin
            trials  <= trials + TRIAL_W'(1);
            state   <= ST_GEN;
            gen_cnt <= '0;
          end
        end
        ST_RUN:    if (last) state <= ST_CHECK;
        ST_CHECK: begin
          if (peak_bad) alert <= 1'b1;
          if (pass) state <= ST_RUN;
          else begin
            trials  <= '0;
            state   <= ST_GEN;
            gen_cnt <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  bits_need_tune_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bits_en |-> tuned);
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && $past(smp_ready)) |-> $stable(cfg_out));
  // R10
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!smp_ready && !tuned && !bits_en));
  // R3
  gen_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GEN) |-> (gen_cnt < GEN_W'(CFG_W)));
endmodule

// File: tb/sim_ring_tune_ctrl.sv
module sim_ring_tune_ctrl;
  localparam int STAGES = 4, SEL_W = 3, CNT_W = 9, MAX_LOG2 = 4, TRIAL_W = 10;
  localparam int CFG_W = STAGES * SEL_W;
  localparam int LOG_W = $clog2(MAX_LOG2 + 1);

  logic clk = 0, rst_n = 0, start = 0, smp_valid = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [LOG_W-1:0] batch_log2 = 2;
  logic [CNT_W-1:0] win_lo = 70, win_hi = 85, max_lim = 100, smp_count = 0;
  logic [TRIAL_W-1:0] trial_lim = 1023;
  logic smp_ready, tuned, bits_en, alert, fail;
  logic [CFG_W-1:0] cfg_out;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_st;
  logic [CFG_W-1:0] m_cfg;

  always #10 clk = ~clk;

  ring_tune_ctrl #(.STAGES(STAGES), .SEL_W(SEL_W), .CNT_W(CNT_W),
                   .MAX_LOG2(MAX_LOG2), .TRIAL_W(TRIAL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .batch_log2(batch_log2),
    .win_lo(win_lo), .win_hi(win_hi), .max_lim(max_lim), .trial_lim(trial_lim),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_count(smp_count),
    .cfg_out(cfg_out), .tuned(tuned), .bits_en(bits_en), .alert(alert), .fail(fail));

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_trial();
    for (int i = 0; i < CFG_W; i++) begin
      logic fb;
      fb = m_st[31] ^ m_st[21] ^ m_st[1] ^ m_st[0];
      m_st  = {m_st[30:0], fb};
      m_cfg = {m_cfg[CFG_W-2:0], fb};
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    m_st = (seed == 0) ? 32'd1 : seed;
    @(negedge clk); start = 0;
  endtask

  // wait for collection to open, then compare the new word (R3)
  task automatic wait_ready();
    int guard = 0;
    while (!smp_ready && guard < 1000) begin @(negedge clk); guard++; end
    model_trial();
    chk(cfg_out == m_cfg, "R3 config word", cfg_out, m_cfg);
  endtask

  task automatic send(input int v);
    int guard = 0;
    smp_valid = 1; smp_count = CNT_W'(v);
    while (!smp_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic trial(input int n, input int a, input int b, input int c, input int d,
                       input logic exp_pass);
    wait_ready();
    chk(tuned == 0, "R8 untuned while searching", tuned, 0);
    send(a); if (n > 1) send(b); if (n > 2) begin send(c); send(d); end
    chk(smp_ready == 0, "R4 decision cycle", smp_ready, 0);
    @(negedge clk);
    chk(tuned == exp_pass, "R5/R6 verdict", tuned, exp_pass);
    chk(bits_en == exp_pass, "R8 bits_en after verdict", bits_en, exp_pass);
  endtask

  task automatic batch(input int n, input int a, input int b, input int c, input int d,
                       input logic exp_keep);
    send(a); if (n > 1) send(b); if (n > 2) begin send(c); send(d); end
    chk(bits_en == 0 && tuned == 1, "R8 bits withheld in check cycle", {tuned, bits_en}, 2);
    @(negedge clk);
    chk(tuned == exp_keep, "R9 monitor verdict", tuned, exp_keep);
    chk(bits_en == exp_keep, "R9 bits_en after monitor", bits_en, exp_keep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_cfg = '0;
    repeat (3) @(negedge clk);
    chk({smp_ready, tuned, bits_en, alert, fail} == 0, "R1 reset flags",
        {smp_ready, tuned, bits_en, alert, fail}, 0);
    chk(cfg_out == 0, "R1 reset config", cfg_out, 0);
    rst_n = 1;
    @(negedge clk);
    pulse_start();
    chk(smp_ready == 0 && bits_en == 0, "R3 no samples during generation", smp_ready, 0);

    trial(4, 50, 50, 50, 50, 0);                  // R6 mean low
    chk(alert == 0, "R7 no alert on low mean", alert, 0);
    trial(4, 90, 90, 90, 90, 0);                  // R6 mean high
    trial(4, 60, 70, 80, 101, 0);                 // R7 peak over limit
    chk(alert == 1, "R7 alert raised", alert, 0 + 1);
    trial(4, 69, 71, 70, 70, 1);                  // R5 lower bound inclusive
    batch(4, 85, 85, 85, 85, 1);                  // R5 upper bound inclusive
    batch(4, 86, 86, 86, 86, 0);                  // R9 drift
    chk(smp_ready == 0, "R9 retune regenerates", smp_ready, 0);

    for (int v = 64; v <= 92; v++) begin
      logic p;
      p = (v >= 70 && v <= 85);
      trial(4, v - 1, v + 1, v, v, p);
      if (p) batch(4, 40, 40, 40, 40, 0);
    end
    chk(alert == 1, "R7 alert sticky", alert, 1);

    trial(4, 75, 75, 75, 75, 1);
    batch(4, 40, 40, 40, 40, 0);                  // R9 resets trial count
    trial_lim = 3;
    trial(4, 50, 50, 50, 50, 0);
    trial(4, 50, 50, 50, 50, 0);
    chk(fail == 0, "R10 not yet failed", fail, 0);
    wait_ready();
    send(50); send(50); send(50); send(50);
    @(negedge clk);
    chk(fail == 1, "R10 fail on limit", fail, 1);
    chk(smp_ready == 0 && tuned == 0, "R10 quiet in fail", smp_ready, 0);

    // R2 zero seed, batch of two; R4 held sample not taken during generation
    seed = 0; batch_log2 = 1; trial_lim = 1023;
    smp_valid = 1; smp_count = 255;
    pulse_start();
    chk(alert == 0, "R2 alert cleared on start", alert, 0);
    trial(2, 70, 80, 0, 0, 1);
    batch(2, 85, 86, 0, 0, 0);
    chk(alert == 0, "R4 held sample not consumed early", alert, 0);
    trial(2, 85, 85, 0, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule